// File: doc/BRIEF.md
# Byte and Bit Operation ALU

This block executes the byte-oriented and bit-oriented instructions of an 8-bit accumulator core. Each cycle it takes a 16-bit instruction word, the working register, the addressed file operand and the current status flags. One clock later it presents the result byte, where that byte belongs (working register or file), whether anything is written at all, the address form (access bank or banked), the 8-bit file address, the updated flags, and a skip request for test-and-skip instructions.

The instruction word holds a 6-bit operation code in bits 15:10, a destination bit in bit 9 (0 = working register, 1 = file), an access bit in bit 8 (0 = access bank with the bank select ignored, 1 = banked) and the file address in bits 7:0. Bit instructions use bits 15:12 as the operation and bits 11:9 as the bit position. The 7-bit forms in bits 15:9 that begin with 0110 select compares, test, set, clear, negate and move-to-file. The status vector is packed {N, OV, Z, DC, C}, with C in bit 0 and N in bit 4. Multiply, register storage and fetch sequencing are outside this block.

Top module: `byte_bit_alu`

## Requirements
- R1: While rst_ni is low, every output is 0. Each output then updates on the rising clock edge that follows its inputs: one cycle of latency.
- R2: banked_o equals instruction bit 8 and file_addr_o equals instruction bits 7:0 for every instruction. For d-bearing byte operations, to_file_o equals instruction bit 9.
- R3: Add (bits 15:10 = 001001) forms f+W. Add with carry (001000) forms f+W+C. Both update C, DC (carry out of bit 3), Z, OV (signed overflow) and N (result bit 7).
- R4: The three subtract forms update all five flags, with C=1 meaning no borrow. They are: 010111 forms f−W, 010110 forms f−W−!C, and 010101 forms W−f−!C.
- R5: Increment (001010), decrement (000001) and negate (bits 15:9 = 0110110, result 0−f, always written to file) update all five flags.
- R6: AND (000101), OR (000100), XOR (000110), complement (000111) and move-file (010100) update only Z and N. C, DC and OV keep their input values.
- R7: Rotate through carry left (001101) and right (001100) update C, Z and N. C takes the bit shifted out. Rotate without carry left (010001) and right (010000) update only Z and N.
- R8: Swap nibbles (001110), set-to-ones (0110100) and move-W-to-file (0110111) update no flag. Clear (0110101) writes 0x00 to the file and sets only Z.
- R9: Set (1000), clear (1001) and toggle (0111) change only bit 11:9 of f. They write to the file and leave all flags unchanged.
- R10: Test-skip-if-clear (1011) and test-skip-if-set (1010) raise skip_o on the tested bit's state. They do not write, leave flags unchanged and drive result_o to 0x00.
- R11: Compares (bits 15:9 = 0110000 / 0110001 / 0110010) skip when the unsigned f < W, f == W or f > W. Test-file (0110011) skips when f is 0. None of them writes or changes a flag.
- R12: Decrement-skip-if-zero (001011), increment-skip-if-zero (001111), decrement-skip-if-nonzero (010011) and increment-skip-if-nonzero (010010) write their result, skip on the stated condition and leave all flags unchanged.
- R13: Any other instruction word gives write_o=0, to_file_o=0, skip_o=0 and result_o=0x00, and passes the flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| wreg_i | input | 8 | Working register value |
| file_i | input | 8 | Addressed file register value |
| status_i | input | 5 | Current flags {N, OV, Z, DC, C} |
| result_o | output | 8 | Result byte (0 when not written) |
| to_file_o | output | 1 | 1 = result goes to file, 0 = working register |
| write_o | output | 1 | Result must be written |
| banked_o | output | 1 | 1 = banked address, 0 = access bank |
| file_addr_o | output | 8 | File address field |
| status_o | output | 5 | Updated flags {N, OV, Z, DC, C} |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The hardest cases to reach are the flag corners where carry, digit carry and signed overflow each flip alone. Examples are an add that overflows the sign but not the carry, a decrement of 0x80, and negating 0x80. These only appear for specific operand pairs. The vector table sets each of them up directly, and it preloads status bits that the instruction must either keep or overwrite, so every flag a wrong mask would touch is visible. Unsigned compares use operands whose order flips under a signed view, such as 0x90 against 0x10.

// File: rtl/byte_bit_alu_pkg.sv
package byte_bit_alu_pkg;
  localparam int DW   = 8;
  localparam int POSW = $clog2(DW);
  localparam int NFLG = 5;
  // flag positions in the status vector
  localparam int FC  = 0;
  localparam int FDC = 1;
  localparam int FZ  = 2;
  localparam int FOV = 3;
  localparam int FN  = 4;

  typedef enum logic [5:0] {
    OP_NONE, OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB,
    OP_INC, OP_DEC, OP_NEG, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV,
    OP_RLC, OP_RRC, OP_RLN, OP_RRN, OP_SWAP, OP_SETF, OP_CLR, OP_MOVWF,
    OP_DECSZ, OP_INCSZ, OP_DECSNZ, OP_INCSNZ,
    OP_CPLT, OP_CPEQ, OP_CPGT, OP_TST,
    OP_BSF, OP_BCF, OP_BTG, OP_BTSC, OP_BTSS
  } op_e;

  typedef struct packed {
    op_e  op;
    logic to_file;
    logic write;
    logic is_bit;
  } dec_t;
endpackage

// File: rtl/byte_bit_alu_dec.sv
module byte_bit_alu_dec
  import byte_bit_alu_pkg::*;
(
  input  logic [6:0] opc_i,   // instruction bits 15:9
  output dec_t       dec_o
);
  op_e  op;
  logic d_bit;

  assign d_bit = opc_i[0];

  always_comb begin
    op = OP_NONE;
    casez (opc_i)
      7'b001001?: op = OP_ADD;
      7'b001000?: op = OP_ADDC;
      7'b010111?: op = OP_SUBWF;
      7'b010110?: op = OP_SUBWFB;
      7'b010101?: op = OP_SUBFWB;
      7'b001010?: op = OP_INC;
      7'b000001?: op = OP_DEC;
      7'b000101?: op = OP_AND;
      7'b000100?: op = OP_IOR;
      7'b000110?: op = OP_XOR;
      7'b000111?: op = OP_COM;
      7'b010100?: op = OP_MOV;
      7'b001101?: op = OP_RLC;
      7'b001100?: op = OP_RRC;
      7'b010001?: op = OP_RLN;
      7'b010000?: op = OP_RRN;
      7'b001110?: op = OP_SWAP;
      7'b001011?: op = OP_DECSZ;
      7'b001111?: op = OP_INCSZ;
      7'b010011?: op = OP_DECSNZ;
      7'b010010?: op = OP_INCSNZ;
      7'b0110000: op = OP_CPLT;
      7'b0110001: op = OP_CPEQ;
      7'b0110010: op = OP_CPGT;
      7'b0110011: op = OP_TST;
      7'b0110100: op = OP_SETF;
      7'b0110101: op = OP_CLR;
      7'b0110110: op = OP_NEG;
      7'b0110111: op = OP_MOVWF;
      7'b1000???: op = OP_BSF;
      7'b1001???: op = OP_BCF;
      7'b0111???: op = OP_BTG;
      7'b1011???: op = OP_BTSC;
      7'b1010???: op = OP_BTSS;
      default:    op = OP_NONE;
    endcase
  end

  always_comb begin
    dec_o.op      = op;
    dec_o.is_bit  = op inside {OP_BSF, OP_BCF, OP_BTG, OP_BTSC, OP_BTSS};
    dec_o.write   = !(op inside {OP_NONE, OP_CPLT, OP_CPEQ, OP_CPGT, OP_TST,
                                 OP_BTSC, OP_BTSS});
    if (!dec_o.write)
      dec_o.to_file = 1'b0;
    else if (op inside {OP_SETF, OP_CLR, OP_NEG, OP_MOVWF, OP_BSF, OP_BCF, OP_BTG})
      dec_o.to_file = 1'b1;
    else
      dec_o.to_file = d_bit;
  end
endmodule

// File: rtl/byte_bit_alu_byte.sv
module byte_bit_alu_byte
  import byte_bit_alu_pkg::*;
(
  input  op_e             op_i,
  input  logic [DW-1:0]   w_i,
  input  logic [DW-1:0]   f_i,
  input  logic            c_i,
  output logic [DW-1:0]   res_o,
  output logic [NFLG-1:0] flg_o,
  output logic [NFLG-1:0] mask_o,
  output logic            skip_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] add_a, add_b;
  logic          add_ci;
  logic [DW:0]   sum;
  logic [HW:0]   half;
  logic          is_arith;

  // shared adder operand selection
  always_comb begin
    add_a  = f_i;
    add_b  = w_i;
    add_ci = 1'b0;
    unique case (op_i)
      OP_ADDC:   add_ci = c_i;
      OP_SUBWF:  begin add_b = ~w_i; add_ci = 1'b1; end
      OP_SUBWFB: begin add_b = ~w_i; add_ci = c_i; end
      OP_SUBFWB: begin add_a = w_i; add_b = ~f_i; add_ci = c_i; end
      OP_INC, OP_INCSZ, OP_INCSNZ: begin add_b = '0; add_ci = 1'b1; end
      OP_DEC, OP_DECSZ, OP_DECSNZ: add_b = '1;
      OP_NEG:    begin add_a = '0; add_b = ~f_i; add_ci = 1'b1; end
      default: ;
    endcase
  end

  assign sum  = {1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, add_ci};
  assign half = {1'b0, add_a[HW-1:0]} + {1'b0, add_b[HW-1:0]} + {{HW{1'b0}}, add_ci};
  assign is_arith = op_i inside {OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB,
                                 OP_INC, OP_DEC, OP_NEG, OP_INCSZ, OP_INCSNZ,
                                 OP_DECSZ, OP_DECSNZ};

  logic cout;
  always_comb begin
    res_o = '0;
    cout  = sum[DW];
    unique case (op_i)
      OP_AND:   res_o = w_i & f_i;
      OP_IOR:   res_o = w_i | f_i;
      OP_XOR:   res_o = w_i ^ f_i;
      OP_COM:   res_o = ~f_i;
      OP_MOV:   res_o = f_i;
      OP_RLC:   begin res_o = {f_i[DW-2:0], c_i}; cout = f_i[DW-1]; end
      OP_RRC:   begin res_o = {c_i, f_i[DW-1:1]}; cout = f_i[0]; end
      OP_RLN:   res_o = {f_i[DW-2:0], f_i[DW-1]};
      OP_RRN:   res_o = {f_i[0], f_i[DW-1:1]};
      OP_SWAP:  res_o = {f_i[HW-1:0], f_i[DW-1:HW]};
      OP_SETF:  res_o = '1;
      OP_CLR:   res_o = '0;
      OP_MOVWF: res_o = w_i;
      default:  if (is_arith) res_o = sum[DW-1:0];
    endcase
  end

  always_comb begin
    flg_o      = '0;
    flg_o[FC]  = cout;
    flg_o[FDC] = half[HW];
    flg_o[FZ]  = (res_o == '0);
    flg_o[FOV] = (add_a[DW-1] == add_b[DW-1]) && (sum[DW-1] != add_a[DW-1]);
    flg_o[FN]  = res_o[DW-1];
  end

  always_comb begin
    mask_o = '0;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB, OP_INC, OP_DEC, OP_NEG:
        mask_o = '1;
      OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV, OP_RLN, OP_RRN:
        begin mask_o[FZ] = 1'b1; mask_o[FN] = 1'b1; end
      OP_RLC, OP_RRC:
        begin mask_o[FC] = 1'b1; mask_o[FZ] = 1'b1; mask_o[FN] = 1'b1; end
      OP_CLR:
        mask_o[FZ] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_DECSZ, OP_INCSZ:   skip_o = (res_o == '0);
      OP_DECSNZ, OP_INCSNZ: skip_o = (res_o != '0);
      OP_CPLT:              skip_o = (f_i < w_i);
      OP_CPEQ:              skip_o = (f_i == w_i);
      OP_CPGT:              skip_o = (f_i > w_i);
      OP_TST:               skip_o = (f_i == '0);
      default:              skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/byte_bit_alu_bit.sv
module byte_bit_alu_bit
  import byte_bit_alu_pkg::*;
(
  input  op_e             op_i,
  input  logic [POSW-1:0] pos_i,
  input  logic [DW-1:0]   f_i,
  output logic [DW-1:0]   res_o,
  output logic            skip_o
);
  logic [DW-1:0] sel;

  // one-hot bit select
  for (genvar g = 0; g < DW; g++) begin : g_sel
    assign sel[g] = (pos_i == POSW'(g));
  end

  always_comb begin
    res_o  = '0;
    skip_o = 1'b0;
    unique case (op_i)
      OP_BSF:  res_o = f_i | sel;
      OP_BCF:  res_o = f_i & ~sel;
      OP_BTG:  res_o = f_i ^ sel;
      OP_BTSC: skip_o = ~|(f_i & sel);
      OP_BTSS: skip_o = |(f_i & sel);
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_bit_alu.sv
module byte_bit_alu
  import byte_bit_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     instr_i,
  input  logic [7:0]      wreg_i,
  input  logic [7:0]      file_i,
  input  logic [4:0]      status_i,
  output logic [7:0]      result_o,
  output logic            to_file_o,
  output logic            write_o,
  output logic            banked_o,
  output logic [7:0]      file_addr_o,
  output logic [4:0]      status_o,
  output logic            skip_o
);
  dec_t            dec;
  logic [DW-1:0]   byte_res, bit_res, res_c;
  logic [NFLG-1:0] byte_flg, byte_mask, flg_c;
  logic            byte_skip, bit_skip;

  byte_bit_alu_dec i_dec (
    .opc_i (instr_i[15:9]),
    .dec_o (dec)
  );

  byte_bit_alu_byte i_byte (
    .op_i   (dec.op),
    .w_i    (wreg_i),
    .f_i    (file_i),
    .c_i    (status_i[FC]),
    .res_o  (byte_res),
    .flg_o  (byte_flg),
    .mask_o (byte_mask),
    .skip_o (byte_skip)
  );

  byte_bit_alu_bit i_bit (
    .op_i   (dec.op),
    .pos_i  (instr_i[11:9]),
    .f_i    (file_i),
    .res_o  (bit_res),
    .skip_o (bit_skip)
  );

  assign res_c = !dec.write ? '0 : (dec.is_bit ? bit_res : byte_res);
  assign flg_c = (status_i & ~byte_mask) | (byte_flg & byte_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      to_file_o   <= 1'b0;
      write_o     <= 1'b0;
      banked_o    <= 1'b0;
      file_addr_o <= '0;
      status_o    <= '0;
      skip_o      <= 1'b0;
    end else begin
      result_o    <= res_c;
      to_file_o   <= dec.to_file;
      write_o     <= dec.write;
      banked_o    <= instr_i[8];
      file_addr_o <= instr_i[7:0];
      status_o    <= flg_c;
      skip_o      <= byte_skip | bit_skip;
    end
  end
endmodule

// File: rtl/byte_bit_alu_chk.sv
module byte_bit_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] instr_i,
  input logic [7:0]  file_i,
  input logic [4:0]  status_i,
  input logic [7:0]  result_o,
  input logic        to_file_o,
  input logic        write_o,
  input logic        banked_o,
  input logic [7:0]  file_addr_o,
  input logic [4:0]  status_o,
  input logic        skip_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !write_o && !skip_o && status_o == '0)); // R1

  AST_ADDR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (file_addr_o == $past(instr_i[7:0]) && banked_o == $past(instr_i[8]))); // R2

  AST_LOGIC_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:12] == 4'b0001) |-> to_file_o == $past(instr_i[9])); // R2

  AST_LOGIC_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:12] == 4'b0001) |->
      (status_o[3] == $past(status_i[3]) && status_o[1:0] == $past(status_i[1:0])
       && status_o[2] == (result_o == 8'h00) && status_o[4] == result_o[7] && !skip_o)); // R6

  AST_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:12] == 4'b1000) |->
      (result_o == ($past(file_i) | (8'h01 << $past(instr_i[11:9]))) && status_o == $past(status_i))); // R9

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:11] == 5'b01100) |->
      (!write_o && status_o == $past(status_i))); // R11

  AST_UNLISTED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(instr_i[15:12] == 4'b1110) |->
      (!write_o && !to_file_o && !skip_o && status_o == $past(status_i))); // R13
endmodule

bind byte_bit_alu byte_bit_alu_chk i_chk (.*);

// File: tb/test_byte_bit_alu.sv
module test_byte_bit_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic [7:0]  wreg_i = '0, file_i = '0;
  logic [4:0]  status_i = '0;
  logic [7:0]  result_o, file_addr_o;
  logic        to_file_o, write_o, banked_o, skip_o;
  logic [4:0]  status_o;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  byte_bit_alu i_byte_bit_alu (
    .clk_i(clk), .rst_ni, .instr_i, .wreg_i, .file_i, .status_i,
    .result_o, .to_file_o, .write_o, .banked_o, .file_addr_o, .status_o, .skip_o
  );

  typedef struct packed {
    logic [15:0] ins;
    logic [7:0]  w;
    logic [7:0]  f;
    logic [4:0]  st;
    logic [7:0]  res;
    logic        tf;
    logic        wr;
    logic [4:0]  sto;
    logic        sk;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  // status = {N,OV,Z,DC,C}
  localparam vec_t VECS [NV] = '{
    '{16'h2625, 8'h7F, 8'h01, 5'h00, 8'h80, 1'b1, 1'b1, 5'h1A, 1'b0, 8'd3},  // R3 signed ovf
    '{16'h2125, 8'hFF, 8'h00, 5'h01, 8'h00, 1'b0, 1'b1, 5'h07, 1'b0, 8'd3},  // R3 carry in
    '{16'h5E25, 8'h20, 8'h10, 5'h00, 8'hF0, 1'b1, 1'b1, 5'h12, 1'b0, 8'd4},  // R4 borrow
    '{16'h5B25, 8'h01, 8'h80, 5'h01, 8'h7F, 1'b1, 1'b1, 5'h09, 1'b0, 8'd4},  // R4 ovf
    '{16'h5425, 8'h05, 8'h05, 5'h00, 8'hFF, 1'b0, 1'b1, 5'h10, 1'b0, 8'd4},  // R4 W-f-1
    '{16'h2A25, 8'h00, 8'hFF, 5'h18, 8'h00, 1'b1, 1'b1, 5'h07, 1'b0, 8'd5},  // R5 inc wrap
    '{16'h0425, 8'h00, 8'h80, 5'h00, 8'h7F, 1'b0, 1'b1, 5'h09, 1'b0, 8'd5},  // R5 dec 0x80
    '{16'h6C25, 8'h00, 8'h80, 5'h00, 8'h80, 1'b1, 1'b1, 5'h1A, 1'b0, 8'd5},  // R5 neg 0x80
    '{16'h1625, 8'hF0, 8'h0F, 5'h1B, 8'h00, 1'b1, 1'b1, 5'h0F, 1'b0, 8'd6},  // R6 and
    '{16'h1825, 8'h0F, 8'hF0, 5'h04, 8'hFF, 1'b0, 1'b1, 5'h10, 1'b0, 8'd6},  // R6 xor
    '{16'h1F25, 8'h00, 8'h5A, 5'h00, 8'hA5, 1'b1, 1'b1, 5'h10, 1'b0, 8'd6},  // R6 com
    '{16'h5025, 8'h00, 8'h00, 5'h10, 8'h00, 1'b0, 1'b1, 5'h04, 1'b0, 8'd6},  // R6 mov
    '{16'h3625, 8'h00, 8'h80, 5'h0A, 8'h00, 1'b1, 1'b1, 5'h0F, 1'b0, 8'd7},  // R7 rlc
    '{16'h4225, 8'h00, 8'h01, 5'h01, 8'h80, 1'b1, 1'b1, 5'h11, 1'b0, 8'd7},  // R7 rrn
    '{16'h3A25, 8'h00, 8'h12, 5'h15, 8'h21, 1'b1, 1'b1, 5'h15, 1'b0, 8'd8},  // R8 swap
    '{16'h6E25, 8'h00, 8'h77, 5'h00, 8'h00, 1'b1, 1'b1, 5'h00, 1'b0, 8'd8},  // R8 movwf
    '{16'h6825, 8'h00, 8'h00, 5'h00, 8'hFF, 1'b1, 1'b1, 5'h00, 1'b0, 8'd8},  // R8 setf
    '{16'h6A25, 8'h00, 8'h77, 5'h11, 8'h00, 1'b1, 1'b1, 5'h15, 1'b0, 8'd8},  // R8 clear
    '{16'h8E25, 8'h00, 8'h00, 5'h04, 8'h80, 1'b1, 1'b1, 5'h04, 1'b0, 8'd9},  // R9 set b7
    '{16'h7025, 8'h00, 8'h55, 5'h00, 8'h54, 1'b1, 1'b1, 5'h00, 1'b0, 8'd9},  // R9 tog b0
    '{16'h9625, 8'h00, 8'hFF, 5'h00, 8'hF7, 1'b1, 1'b1, 5'h00, 1'b0, 8'd9},  // R9 clr b3
    '{16'hB425, 8'h00, 8'hFB, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b1, 8'd10}, // R10 sc
    '{16'hA425, 8'h00, 8'hFB, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b0, 8'd10}, // R10 ss
    '{16'h6425, 8'h10, 8'h90, 5'h1F, 8'h00, 1'b0, 1'b0, 5'h1F, 1'b1, 8'd11}, // R11 gt
    '{16'h6025, 8'h10, 8'h90, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b0, 8'd11}, // R11 lt
    '{16'h6225, 8'h33, 8'h33, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b1, 8'd11}, // R11 eq
    '{16'h6625, 8'h00, 8'h00, 5'h00, 8'h00, 1'b0, 1'b0, 5'h00, 1'b1, 8'd11}, // R11 tst
    '{16'h2E25, 8'h00, 8'h01, 5'h00, 8'h00, 1'b1, 1'b1, 5'h00, 1'b1, 8'd12}, // R12 decsz
    '{16'h4825, 8'h00, 8'hFF, 5'h00, 8'h00, 1'b0, 1'b1, 5'h00, 1'b0, 8'd12}, // R12 incsnz
    '{16'hE025, 8'h00, 8'h12, 5'h0B, 8'h00, 1'b0, 1'b0, 5'h0B, 1'b0, 8'd13}, // R13
    '{16'h0225, 8'h05, 8'h12, 5'h0B, 8'h00, 1'b0, 1'b0, 5'h0B, 1'b0, 8'd13}  // R13
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #400000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: outputs held at zero in reset
    instr_i = 16'h2625; wreg_i = 8'h7F; file_i = 8'h01;
    repeat (3) @(negedge clk);
    check("R1 reset result", 32'(result_o), 32'h0);
    check("R1 reset write/skip", {30'd0, write_o, skip_o}, 32'h0);
    check("R1 reset status", 32'(status_o), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      instr_i  = VECS[i].ins;
      wreg_i   = VECS[i].w;
      file_i   = VECS[i].f;
      status_i = VECS[i].st;
      @(negedge clk);
      check($sformatf("R%0d v%0d result", VECS[i].req, i), 32'(result_o), 32'(VECS[i].res));
      check($sformatf("R%0d v%0d dest", VECS[i].req, i), 32'(to_file_o), 32'(VECS[i].tf));
      check($sformatf("R%0d v%0d write", VECS[i].req, i), 32'(write_o), 32'(VECS[i].wr));
      check($sformatf("R%0d v%0d status", VECS[i].req, i), 32'(status_o), 32'(VECS[i].sto));
      check($sformatf("R%0d v%0d skip", VECS[i].req, i), 32'(skip_o), 32'(VECS[i].sk));
      check($sformatf("R2 v%0d addr", i), 32'(file_addr_o), 32'h25);
      check($sformatf("R2 v%0d banked", i), 32'(banked_o), 32'(VECS[i].ins[8]));
    end

    // R2: banked form, other address
    instr_i = 16'h27C3; wreg_i = 8'h01; file_i = 8'h01; status_i = 5'h00;
    @(negedge clk);
    check("R2 banked", 32'(banked_o), 32'h1);
    check("R2 addr", 32'(file_addr_o), 32'hC3);
    check("R2 dest file", 32'(to_file_o), 32'h1);

    // R10: test-set on a set bit skips
    instr_i = 16'hAE25; file_i = 8'h80;
    @(negedge clk);
    check("R10 set bit7 skip", 32'(skip_o), 32'h1);

    // R12: increment-skip-if-zero wraps to zero and skips
    instr_i = 16'h3E25; file_i = 8'hFF; status_i = 5'h1F;
    @(negedge clk);
    check("R12 incsz skip", 32'(skip_o), 32'h1);
    check("R12 incsz flags kept", 32'(status_o), 32'h1F);

    // R1: asynchronous reset mid-run
    instr_i = 16'h2625; wreg_i = 8'h7F; file_i = 8'h01;
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async reset result", 32'(result_o), 32'h0);
    check("R1 async reset status", 32'(status_o), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule